// File: doc/BRIEF.md
# DMA Channel Status and Error Tracker

This block holds the status word of one DMA channel and the event logic behind it. It watches the channel's programmed byte count, source address, destination address and transfer size code. It also takes simple strobes from the rest of the channel: a start condition, a read-phase bus error, a write-phase bus error and a channel-selected indication from the arbiter. From these it keeps sticky error flags, a busy flag, a done flag and a pending-request indication.

Software reads the 8-bit status word combinationally. The only way software can change it is by writing a one to the done bit, which clears the done flag and all three error flags together. Addresses, data movement, arbitration and bus timing belong to other blocks. The byte count is counted down outside this block and is only observed here. No data stream passes through the block, so every pin is a plain control or status signal with no handshake.

Top module: `dma_chan_status`

## Requirements
- R1: After reset the status word reads 0x00. The layout is: configuration error at bit 6, read-side bus error at bit 5, write-side bus error at bit 4, pending request at bit 2, busy at bit 1 and done at bit 0. Bits 7 and 3 always read 0.
- R2: A start strobe while idle with a byte count of zero sets the configuration error and done bits on the next cycle, and busy stays 0.
- R3: Size code k selects units of 2^k bytes. A start strobe while idle with a source address, destination address or byte count that is not a multiple of 2^k sets the configuration error and done bits, and busy stays 0.
- R4: A start strobe while idle with a consistent configuration sets busy on the next cycle. A start strobe while busy has no effect.
- R5: A read-phase bus error while busy sets the read-side error bit, clears busy and sets done, all on the next cycle.
- R6: A write-phase bus error while busy clears busy and sets done. It sets the write-side error bit in dual-address mode and the read-side error bit in single-address mode.
- R7: While busy, a byte count of zero clears busy and sets done on the next cycle.
- R8: The pending-request bit reads 1 exactly when busy is 1 and the channel-selected input is 0. It follows that input in the same cycle.
- R9: A register write with bit 0 set clears the configuration error, both bus error bits and done on the next cycle. Writes with bit 0 clear have no effect, whatever the other bits hold. A set event in the same cycle as a clear wins.
- R10: Bus error strobes while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count | input | CNT_W | Remaining byte count, counted down outside the block |
| cfg_src | input | ADDR_W | Source address |
| cfg_dst | input | ADDR_W | Destination address |
| cfg_size | input | SIZE_W | Transfer size code k, units of 2^k bytes |
| single_mode | input | 1 | 1 when the channel runs single-address accesses |
| start_req | input | 1 | Start condition strobe |
| berr_rd | input | 1 | Bus error during the read phase |
| berr_wr | input | 1 | Bus error during the write phase |
| chan_sel | input | 1 | Channel currently selected by the arbiter |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | 8 | Status register write data |
| reg_rd_data | output | 8 | Status word |

## Verification
The assertions assume that the strobes are synchronous single-cycle pulses that are valid on every clock after reset. They also assume that the byte count input changes only as the outside counter moves it. The bench drives every input at the falling edge and holds it across the next rising edge. The byte count is kept nonzero at each start that is meant to succeed, and is set to zero only to end a running transfer. Error strobes arrive both while idle and while busy, and one arrives in the same cycle as a clear write, to cover the priority rule.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned ST_W     = 8;
  localparam int unsigned B_CFGERR = 6;
  localparam int unsigned B_ERRRD  = 5;
  localparam int unsigned B_ERRWR  = 4;
  localparam int unsigned B_PEND   = 2;
  localparam int unsigned B_BUSY   = 1;
  localparam int unsigned B_DONE   = 0;

  typedef struct packed {
    logic cfg_err;
    logic err_rd;
    logic err_wr;
    logic done;
  } sticky_t;
endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [SIZE_W-1:0] size,
  output logic              cfg_bad
);
  localparam int unsigned LOW_BITS = (1 << SIZE_W) - 1;

  logic [LOW_BITS-1:0] mask;

  // one mask bit per low address bit that must be zero for the size
  for (genvar i = 0; i < LOW_BITS; i++) begin : g_mask
    assign mask[i] = (SIZE_W'(i) < size);
  end

  logic cnt_zero, cnt_mis, src_mis, dst_mis;
  assign cnt_zero = (count == '0);
  assign cnt_mis  = |(count[LOW_BITS-1:0] & mask);
  assign src_mis  = |(src[LOW_BITS-1:0] & mask);
  assign dst_mis  = |(dst[LOW_BITS-1:0] & mask);
  assign cfg_bad  = cnt_zero | cnt_mis | src_mis | dst_mis;
endmodule

// File: rtl/dma_busy_ctrl.sv
module dma_busy_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic cfg_bad,
  input  logic berr_rd,
  input  logic berr_wr,
  input  logic cnt_zero,
  output logic busy,
  output logic go_bad,
  output logic term
);
  logic busy_q;
  logic go_ok;

  assign go_ok  = start_req & ~busy_q & ~cfg_bad;
  assign go_bad = start_req & ~busy_q & cfg_bad;
  assign term   = busy_q & (berr_rd | berr_wr | cnt_zero);
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     busy_q <= 1'b0;
    else if (term)  busy_q <= 1'b0;
    else if (go_ok) busy_q <= 1'b1;
  end

  // R2/R3: a rejected start never begins a transfer
  a_r3_bad_start_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy_q && cfg_bad) |=> !busy_q);
  // R5/R6: any bus error during a transfer ends it
  a_r5_err_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (berr_rd || berr_wr)) |=> !busy_q);
  // R4: busy is only entered from an accepted start
  a_r4_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_req));
endmodule

// File: rtl/dma_err_flags.sv
module dma_err_flags
  import dma_stat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    busy,
  input  logic    go_bad,
  input  logic    term,
  input  logic    berr_rd,
  input  logic    berr_wr,
  input  logic    single_mode,
  input  logic    clr,
  output sticky_t flags
);
  sticky_t q, set_v;

  always_comb begin
    set_v.cfg_err = go_bad;
    set_v.err_rd  = busy & (berr_rd | (berr_wr & single_mode));
    set_v.err_wr  = busy & berr_wr & ~single_mode;
    set_v.done    = term | go_bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? sticky_t'('0) : q) | set_v;
  end

  assign flags = q;

  // R9: flags survive when no clear is written
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> ((q & $past(q)) == $past(q)));
  // R9: a clear with no set event empties every flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !go_bad && !term && !busy) |=> (q == '0));
  // R10: bus errors while idle leave the error flags alone
  a_r10_idle_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_bad && !clr) |=> $stable(q));
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              single_mode,
  input  logic              start_req,
  input  logic              berr_rd,
  input  logic              berr_wr,
  input  logic              chan_sel,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wr_data,
  output logic [7:0]        reg_rd_data
);
  logic    cfg_bad, busy, go_bad, term, clr, pend;
  sticky_t flags;

  dma_cfg_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_chk (
    .count(cfg_count), .src(cfg_src), .dst(cfg_dst), .size(cfg_size),
    .cfg_bad(cfg_bad)
  );

  dma_busy_ctrl u_busy (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_bad(cfg_bad),
    .berr_rd(berr_rd), .berr_wr(berr_wr), .cnt_zero(cfg_count == '0),
    .busy(busy), .go_bad(go_bad), .term(term)
  );

  assign clr = reg_wr_en & reg_wr_data[B_DONE];

  dma_err_flags u_flags (
    .clk(clk), .rst_n(rst_n), .busy(busy), .go_bad(go_bad), .term(term),
    .berr_rd(berr_rd), .berr_wr(berr_wr), .single_mode(single_mode),
    .clr(clr), .flags(flags)
  );

  assign pend = busy & ~chan_sel;

  always_comb begin
    reg_rd_data           = '0;
    reg_rd_data[B_CFGERR] = flags.cfg_err;
    reg_rd_data[B_ERRRD]  = flags.err_rd;
    reg_rd_data[B_ERRWR]  = flags.err_wr;
    reg_rd_data[B_PEND]   = pend;
    reg_rd_data[B_BUSY]   = busy;
    reg_rd_data[B_DONE]   = flags.done;
  end

  // R7: an exhausted count ends the transfer with done set
  a_r7_count_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_count == '0) |=> (!reg_rd_data[B_BUSY] && reg_rd_data[B_DONE]));
  // R2: a start on an empty count flags a configuration error
  a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy && cfg_count == '0) |=> reg_rd_data[B_CFGERR]);
endmodule

// File: tb/dma_chan_status_tb_top.sv
module dma_chan_status_tb_top;
  localparam int AW = 32, CW = 24, SW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_count;
  logic [AW-1:0] cfg_src, cfg_dst;
  logic [SW-1:0] cfg_size;
  logic single_mode, start_req, berr_rd, berr_wr, chan_sel, reg_wr_en;
  logic [7:0] reg_wr_data, reg_rd_data;

  always #2.5 clk = ~clk;

  dma_chan_status #(.ADDR_W(AW), .CNT_W(CW), .SIZE_W(SW)) dut_i (.*);

  int total = 0, bad = 0;
  bit m_ce, m_brd, m_bwr, m_busy, m_done;

  function automatic bit cfg_wrong();
    longint sz = longint'(1) << cfg_size;
    return (cfg_count == 0) || (cfg_count % sz != 0) ||
           (cfg_src % sz != 0) || (cfg_dst % sz != 0);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_word();
    logic [7:0] w = '0;
    w[6] = m_ce; w[5] = m_brd; w[4] = m_bwr;
    w[2] = m_busy & ~chan_sel; w[1] = m_busy; w[0] = m_done;
    return w;
  endfunction

  // advance model by one clock with current inputs, then compare at negedge
  task automatic cyc(string tag);
    bit n_ce = m_ce, n_brd = m_brd, n_bwr = m_bwr, n_busy = m_busy, n_done = m_done;
    if (reg_wr_en && reg_wr_data[0]) begin n_ce = 0; n_brd = 0; n_bwr = 0; n_done = 0; end
    if (m_busy) begin
      if (berr_rd || (berr_wr && single_mode)) n_brd = 1;
      if (berr_wr && !single_mode) n_bwr = 1;
      if (berr_rd || berr_wr || cfg_count == 0) begin n_busy = 0; n_done = 1; end
    end else if (start_req) begin
      if (cfg_wrong()) begin n_ce = 1; n_done = 1; end
      else n_busy = 1;
    end
    @(posedge clk);
    m_ce = n_ce; m_brd = n_brd; m_bwr = n_bwr; m_busy = n_busy; m_done = n_done;
    @(negedge clk);
    chk(tag, reg_rd_data, model_word());
    start_req = 0; berr_rd = 0; berr_wr = 0; reg_wr_en = 0; reg_wr_data = '0;
  endtask

  task automatic clear_all();
    reg_wr_en = 1; reg_wr_data = 8'h01; cyc("R9 clear");
  endtask

  task automatic setup(logic [CW-1:0] c, logic [AW-1:0] s, logic [AW-1:0] d, logic [SW-1:0] z);
    cfg_count = c; cfg_src = s; cfg_dst = d; cfg_size = z;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; start_req = 0; berr_rd = 0; berr_wr = 0; chan_sel = 0;
    reg_wr_en = 0; reg_wr_data = '0; single_mode = 0;
    setup(24'd16, 32'h1000, 32'h2000, 2'd2);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 reset", reg_rd_data, 8'h00);

    // R2 zero count
    setup(0, 32'h1000, 32'h2000, 2'd2);
    start_req = 1; cyc("R2 zero count");
    chk("R2 word", reg_rd_data, 8'h41);
    // R9 writes without bit 0 ignored
    reg_wr_en = 1; reg_wr_data = 8'hFE; cyc("R9 no-op write");
    chk("R9 kept", reg_rd_data, 8'h41);
    clear_all();
    chk("R9 cleared", reg_rd_data, 8'h00);

    // R3 misalignments
    setup(24'd16, 32'h1002, 32'h2000, 2'd2); start_req = 1; cyc("R3 src");
    chk("R3 src word", reg_rd_data, 8'h41); clear_all();
    setup(24'd16, 32'h1000, 32'h2004, 2'd3); start_req = 1; cyc("R3 dst");
    chk("R3 dst word", reg_rd_data, 8'h41); clear_all();
    setup(24'd6, 32'h1000, 32'h2000, 2'd2); start_req = 1; cyc("R3 count");
    chk("R3 count word", reg_rd_data, 8'h41); clear_all();

    // R4 good start, byte size with odd addresses
    setup(24'd5, 32'h1001, 32'h2003, 2'd0); start_req = 1; cyc("R4 start");
    chk("R4 busy", reg_rd_data, 8'h06);
    chan_sel = 1; #1; chk("R8 selected", reg_rd_data, 8'h02);
    start_req = 1; cyc("R4 start while busy");
    chan_sel = 0; #1; chk("R8 released", reg_rd_data, 8'h06);
    berr_rd = 0; cyc("R4 hold");
    cfg_count = 0; cyc("R7 count zero");
    chk("R7 done", reg_rd_data, 8'h01);
    clear_all();

    // R5 read error
    setup(24'd16, 32'h1000, 32'h2000, 2'd2); start_req = 1; cyc("R4 start");
    berr_rd = 1; cyc("R5 read err");
    chk("R5 word", reg_rd_data, 8'h21); clear_all();

    // R6 write error, dual then single
    start_req = 1; cyc("R4 start");
    berr_wr = 1; cyc("R6 write err dual");
    chk("R6 dual word", reg_rd_data, 8'h11); clear_all();
    single_mode = 1; start_req = 1; cyc("R4 start");
    berr_wr = 1; cyc("R6 write err single");
    chk("R6 single word", reg_rd_data, 8'h21); clear_all();
    single_mode = 0;

    // R10 idle errors
    berr_rd = 1; berr_wr = 1; cyc("R10 idle err");
    chk("R10 word", reg_rd_data, 8'h00);

    // R9 set wins over same-cycle clear
    start_req = 1; cyc("R4 start");
    berr_rd = 1; reg_wr_en = 1; reg_wr_data = 8'h01; cyc("R9 set wins");
    chk("R9 set wins word", reg_rd_data, 8'h21);
    clear_all();
    for (int i = 0; i < 4; i++) cyc("R1 idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule